// File: doc/BRIEF.md
# Multichannel Serial ADC Frame Capture

This block sits between an eight-channel delta-sigma converter and an on-chip consumer of samples. All eight channels leave the converter back to back on a single serial data line. Before any frame is read, the block runs the converter's start-up sequence. It then waits for a data-ready falling edge, drives a serial clock whose half-period is programmable, and shifts in the channel words one after another.

Every 24-bit channel word is combined with a one-hot channel tag to form a 32-bit word. That word is offered on a valid/ready output. While the consumer is not ready, the block pauses between words. It never pauses inside a word.

The block also drives eight group power-down outputs from a configuration byte. Those outputs can be loaded only when a run starts with the load flag set. A run continues while the run code equals 1. Once the code changes, the block stops at the next frame boundary and clears every output it drives.

Top module: `adc_frame_capture`

## Requirements
- R1: After reset, and while idle, `adc_sclk`, `adc_sync`, `word_valid` and `pd_out` are all 0.
- R2: A run starts when `run_code` equals 1. From the next cycle `adc_sync` is 1 and `settle_pulses` clock pulses are issued, each N cycles high and N cycles low. Then `adc_sync` is 0 for N cycles, and then returns to 1. A count of 0 skips the pulses.
- R3: After start-up, a frame begins only after `adc_drdy` has been sampled 1 and then sampled 0. While `adc_drdy` stays 0, no clock is issued.
- R4: Each data bit is one `adc_sclk` pulse of N cycles high followed by N cycles low. Each channel word takes exactly 24 pulses.
- R5: `adc_dout` is sampled at the end of the first low cycle of each pulse. Bits are assembled most significant first into `word_data[23:0]`.
- R6: Words leave in channel order 1 to 8. For channel k, `word_data[31:24]` is the one-hot tag 1 << (k-1), so channel 1 gives 0x01 and channel 8 gives 0x80.
- R7: While `word_valid` is 1 and `word_ready` is 0, `word_valid` stays 1, `word_data` stays unchanged and `adc_sclk` stays 0. The next word starts on the cycle after acceptance.
- R8: N is `clk_half`, latched when the run starts. A value of 0 behaves as N = 1.
- R9: `pd_out` takes `pd_word` at run start only if `cfg_load` is 1 at that moment. Otherwise it stays all zero. Changes to `pd_word` or `cfg_load` during a run have no effect.
- R10: `run_code` is examined only while waiting for data-ready. If it is not 1 there, the next cycle shows all outputs cleared as in R1, and no further frame is read. A change during a frame lets that frame finish.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_code | input | 2 | Run state; 1 runs capture, any other value stops it |
| clk_half | input | 16 | Serial clock half-period in cycles (0 treated as 1) |
| settle_pulses | input | 16 | Number of start-up dummy clock pulses |
| pd_word | input | 8 | Group power-down control byte |
| cfg_load | input | 1 | Configuration-change flag, sampled at run start |
| adc_drdy | input | 1 | Converter data-ready |
| adc_dout | input | 1 | Converter serial data |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_sync | output | 1 | Converter sync line (low pulse restarts conversion) |
| pd_out | output | 8 | Group power-down outputs |
| word_valid | output | 1 | Output word valid |
| word_ready | input | 1 | Downstream ready |
| word_data | output | 32 | Channel tag in [31:24], sample in [23:0] |

## Verification
The assertions assume the following:
- `clk_half`, `settle_pulses` and the configuration inputs matter only in the idle cycle that starts a run.
- `word_ready` is only looked at while a word is offered.
- `adc_dout` only matters on the cycle that ends the first low cycle of a pulse.

The stimulus changes `clk_half`, `pd_word` and `cfg_load` mid-run to confirm those changes are ignored. It holds `adc_dout` at the inverted bit value everywhere except around the capture cycle, so a sample taken in any other cycle shows up as a wrong word. `run_code` is changed both at a frame boundary and in the middle of a frame, so both stop paths are exercised.

// File: rtl/adcf_pkg.sv
package adcf_pkg;

    // Sequencer states of the capture controller
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETTLE_HI,
        ST_SETTLE_LO,
        ST_SYNC_LO,
        ST_WAIT_HI,
        ST_WAIT_LO,
        ST_BIT_HI,
        ST_BIT_LO,
        ST_PRESENT
    } cap_state_e;

    localparam int unsigned DEF_CHANNELS = 8;
    localparam int unsigned DEF_SAMPLE_W = 24;
    localparam int unsigned DEF_CNT_W    = 16;
    localparam int unsigned DEF_RUN_W    = 2;

    // States whose duration is set by the phase timer
    function automatic logic is_timed(cap_state_e s);
        return (s == ST_SETTLE_HI) || (s == ST_SETTLE_LO) || (s == ST_SYNC_LO) ||
               (s == ST_BIT_HI)    || (s == ST_BIT_LO);
    endfunction

    // States in which the serial clock is high
    function automatic logic clock_high(cap_state_e s);
        return (s == ST_SETTLE_HI) || (s == ST_BIT_HI);
    endfunction

    // Sync is high whenever a run is active, apart from its low pulse
    function automatic logic sync_level(cap_state_e s);
        return (s != ST_IDLE) && (s != ST_SYNC_LO);
    endfunction

    // Half-period reload value, with a zero count forced to one cycle
    function automatic logic [DEF_CNT_W-1:0] half_reload(logic [DEF_CNT_W-1:0] half);
        return (half == '0) ? '0 : half - DEF_CNT_W'(1);
    endfunction

endpackage

// File: rtl/adcf_phase_timer.sv
module adcf_phase_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] load_val,
    output logic             done,
    output logic             first
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] top_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            top_q <= '0;
        end else if (start) begin
            cnt   <= load_val;
            top_q <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign done  = (cnt == '0);
    assign first = (cnt == top_q);

    // R4
    phase_count_chk: assert property (@(posedge clk) disable iff (rst)
        (!start && cnt != '0) |=> (cnt < $past(cnt)));

endmodule

// File: rtl/adcf_shifter.sv
module adcf_shifter #(
    parameter int unsigned WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             shift_en,
    input  logic             din,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            q <= '0;
        end else if (shift_en) begin
            q <= {q[WIDTH-2:0], din};
        end
    end

    // R5
    shift_in_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !clr) |=> (q[0] == $past(din)));

endmodule

// File: rtl/adcf_group_power.sv
module adcf_group_power #(
    parameter int unsigned GROUPS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              load,
    input  logic [GROUPS-1:0] word,
    output logic [GROUPS-1:0] pd
);
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            pd <= '0;
        end else if (load) begin
            pd <= word;
        end
    end

    // R9
    pd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !clear) |=> $stable(pd));

endmodule

// File: rtl/adc_frame_capture.sv
module adc_frame_capture
    import adcf_pkg::*;
#(
    parameter int unsigned CHANNELS = DEF_CHANNELS,
    parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
    parameter int unsigned CNT_W    = DEF_CNT_W,
    parameter int unsigned RUN_W    = DEF_RUN_W,
    parameter int unsigned RUN_CODE = 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [RUN_W-1:0]             run_code,
    input  logic [CNT_W-1:0]             clk_half,
    input  logic [CNT_W-1:0]             settle_pulses,
    input  logic [CHANNELS-1:0]          pd_word,
    input  logic                         cfg_load,
    input  logic                         adc_drdy,
    input  logic                         adc_dout,
    output logic                         adc_sclk,
    output logic                         adc_sync,
    output logic [CHANNELS-1:0]          pd_out,
    output logic                         word_valid,
    input  logic                         word_ready,
    output logic [CHANNELS+SAMPLE_W-1:0] word_data
);
    localparam int unsigned WORD_W    = CHANNELS + SAMPLE_W;
    localparam int unsigned CH_IDX_W  = (CHANNELS > 1) ? $clog2(CHANNELS) : 1;
    localparam int unsigned BIT_IDX_W = $clog2(SAMPLE_W);

    cap_state_e cur, nxt;

    logic                 run_go;
    logic [CNT_W-1:0]     reload_q;
    logic [CNT_W-1:0]     reload_fresh;
    logic [CNT_W-1:0]     reload_use;
    logic [CNT_W-1:0]     pulses_left;
    logic [BIT_IDX_W-1:0] bit_idx;
    logic [CH_IDX_W-1:0]  ch_idx;
    logic                 last_bit;
    logic                 last_ch;
    logic                 ph_start;
    logic                 ph_done;
    logic                 ph_first;
    logic                 shift_en;
    logic                 leaving_idle;
    logic                 entering_idle;
    logic [SAMPLE_W-1:0]  sample_q;
    logic [CHANNELS-1:0]  tag;

    assign run_go       = (run_code == RUN_W'(RUN_CODE));
    assign reload_fresh = (clk_half == '0) ? '0 : clk_half - CNT_W'(1);
    assign reload_use   = (cur == ST_IDLE) ? reload_fresh : reload_q;
    assign last_bit     = (bit_idx == BIT_IDX_W'(SAMPLE_W - 1));
    assign last_ch      = (ch_idx == CH_IDX_W'(CHANNELS - 1));
    assign leaving_idle = (cur == ST_IDLE) && (nxt != ST_IDLE);
    assign entering_idle = (cur != ST_IDLE) && (nxt == ST_IDLE);

    // Next-state decode
    always_comb begin
        nxt = cur;
        case (cur)
            ST_IDLE:
                if (run_go) nxt = (settle_pulses != '0) ? ST_SETTLE_HI : ST_SYNC_LO;
            ST_SETTLE_HI:
                if (ph_done) nxt = ST_SETTLE_LO;
            ST_SETTLE_LO:
                if (ph_done) nxt = (pulses_left <= CNT_W'(1)) ? ST_SYNC_LO : ST_SETTLE_HI;
            ST_SYNC_LO:
                if (ph_done) nxt = ST_WAIT_HI;
            ST_WAIT_HI:
                if (!run_go) nxt = ST_IDLE;
                else if (adc_drdy) nxt = ST_WAIT_LO;
            ST_WAIT_LO:
                if (!run_go) nxt = ST_IDLE;
                else if (!adc_drdy) nxt = ST_BIT_HI;
            ST_BIT_HI:
                if (ph_done) nxt = ST_BIT_LO;
            ST_BIT_LO:
                if (ph_done) nxt = last_bit ? ST_PRESENT : ST_BIT_HI;
            ST_PRESENT:
                if (word_ready) nxt = last_ch ? ST_WAIT_HI : ST_BIT_HI;
            default:
                nxt = ST_IDLE;
        endcase
    end

    assign ph_start = is_timed(nxt) && (nxt != cur);
    assign shift_en = (cur == ST_BIT_LO) && ph_first;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur         <= ST_IDLE;
            reload_q    <= '0;
            pulses_left <= '0;
            bit_idx     <= '0;
            ch_idx      <= '0;
        end else begin
            cur <= nxt;
            if (leaving_idle) begin
                reload_q    <= reload_fresh;
                pulses_left <= settle_pulses;
            end else if (cur == ST_SETTLE_LO && ph_done) begin
                pulses_left <= pulses_left - CNT_W'(1);
            end
            if (cur == ST_IDLE) begin
                bit_idx <= '0;
                ch_idx  <= '0;
            end else begin
                if (cur == ST_BIT_LO && ph_done)
                    bit_idx <= last_bit ? '0 : bit_idx + BIT_IDX_W'(1);
                if (cur == ST_PRESENT && word_ready)
                    ch_idx <= last_ch ? '0 : ch_idx + CH_IDX_W'(1);
            end
        end
    end

    adcf_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .start    (ph_start),
        .load_val (reload_use),
        .done     (ph_done),
        .first    (ph_first)
    );

    adcf_shifter #(.WIDTH(SAMPLE_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .clr      (cur == ST_IDLE),
        .shift_en (shift_en),
        .din      (adc_dout),
        .q        (sample_q)
    );

    adcf_group_power #(.GROUPS(CHANNELS)) u_power (
        .clk   (clk),
        .rst   (rst),
        .clear (entering_idle),
        .load  (leaving_idle && cfg_load),
        .word  (pd_word),
        .pd    (pd_out)
    );

    assign tag        = CHANNELS'(1) << ch_idx;
    assign adc_sclk   = clock_high(cur);
    assign adc_sync   = sync_level(cur);
    assign word_valid = (cur == ST_PRESENT);
    assign word_data  = {tag, sample_q};

    // Checker-only run length of the serial clock high phase
    logic [CNT_W-1:0] hi_run;
    always_ff @(posedge clk) begin
        if (rst) hi_run <= '0;
        else     hi_run <= adc_sclk ? hi_run + CNT_W'(1) : '0;
    end

    // R8
    sclk_len_chk: assert property (@(posedge clk) disable iff (rst)
        adc_sclk |-> (hi_run <= reload_q));

    // R7
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (word_valid && !word_ready) |=> (word_valid && $stable(word_data)));

    // R7
    no_clk_present_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> !adc_sclk);

    // R6
    tag_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> ($countones(word_data[WORD_W-1:SAMPLE_W]) == 1));

    // R3
    drdy_qual_chk: assert property (@(posedge clk) disable iff (rst)
        (cur == ST_WAIT_LO) |-> $past(adc_drdy));

    // R2
    sync_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!adc_sync && cur != ST_IDLE) |-> !adc_sclk);

    // R1
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (cur == ST_IDLE) |-> (pd_out == '0 && !word_valid));

endmodule

// File: tb/adc_frame_capture_bench.sv
module adc_frame_capture_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  run_code;
    logic [15:0] clk_half;
    logic [15:0] settle_pulses;
    logic [7:0]  pd_word;
    logic        cfg_load;
    logic        adc_drdy;
    logic        adc_dout;
    logic        adc_sclk;
    logic        adc_sync;
    logic [7:0]  pd_out;
    logic        word_valid;
    logic        word_ready;
    logic [31:0] word_data;

    // Expected outputs of the behavioural model
    logic        e_sclk, e_sync, e_valid;
    logic [31:0] e_data;
    logic [7:0]  e_pd;

    int compared   = 0;
    int mismatched = 0;
    bit finished   = 0;

    logic [23:0] smp [8];
    int          stl [8];

    always #2 clk = ~clk;

    adc_frame_capture u_adc_frame_capture (
        .clk           (clk),
        .rst           (rst),
        .run_code      (run_code),
        .clk_half      (clk_half),
        .settle_pulses (settle_pulses),
        .pd_word       (pd_word),
        .cfg_load      (cfg_load),
        .adc_drdy      (adc_drdy),
        .adc_dout      (adc_dout),
        .adc_sclk      (adc_sclk),
        .adc_sync      (adc_sync),
        .pd_out        (pd_out),
        .word_valid    (word_valid),
        .word_ready    (word_ready),
        .word_data     (word_data)
    );

    // One clock: advance, then compare every output with the model
    task automatic cyc(input string tag);
        @(posedge clk);
        #1;
        compared++;
        if (adc_sclk !== e_sclk || adc_sync !== e_sync || word_valid !== e_valid ||
            pd_out !== e_pd || (e_valid && word_data !== e_data)) begin
            mismatched++;
            $display("FAIL %s t=%0t actual sclk=%b sync=%b valid=%b data=%h pd=%h expected sclk=%b sync=%b valid=%b data=%h pd=%h",
                     tag, $time, adc_sclk, adc_sync, word_valid, word_data, pd_out,
                     e_sclk, e_sync, e_valid, e_data, e_pd);
        end
    endtask

    task automatic expect_idle();
        e_sclk = 0; e_sync = 0; e_valid = 0; e_pd = 8'h00;
    endtask

    task automatic expect_wait();
        e_sclk = 0; e_sync = 1; e_valid = 0;
    endtask

    // Start-up sequence with n-cycle half-period and p settle pulses (R2)
    task automatic startup(input int n, input int p, input logic [7:0] pdv);
        e_pd = pdv; e_valid = 0; e_sync = 1;
        for (int k = 0; k < p; k++) begin
            e_sclk = 1;
            repeat (n) cyc("R2 settle pulse high");
            e_sclk = 0;
            repeat (n) cyc("R2 settle pulse low");
        end
        e_sync = 0; e_sclk = 0;
        repeat (n) cyc("R2 sync low pulse");
        expect_wait();
        cyc("R2 sync back high");
    endtask

    // One frame; stop_ch >= 0 drops run_code at the start of that channel (R10)
    task automatic frame(input int n, input int hold_hi, input int stop_ch);
        adc_drdy = 1;
        expect_wait();
        repeat (hold_hi) cyc("R3 data-ready high");
        adc_drdy = 0;
        for (int ch = 0; ch < 8; ch++) begin
            if (ch == stop_ch) run_code = 2'd2;
            for (int b = 23; b >= 0; b--) begin
                e_sclk = 1; e_valid = 0;
                cyc("R4 bit high");
                adc_dout = ~smp[ch][b];
                repeat (n - 1) cyc("R4 bit high");
                e_sclk = 0;
                cyc("R4 bit low");
                adc_dout = smp[ch][b];
                repeat (n - 1) cyc("R4 bit low");
            end
            e_valid = 1;
            e_data  = {8'(1 << ch), smp[ch]};
            for (int i = 0; i <= stl[ch]; i++) begin
                word_ready = 0;
                cyc("R5 R6 R7 word present");
            end
            word_ready = 1;
            e_valid = 0;
        end
        expect_wait();
        cyc("R3 back to wait after frame");
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin : main
        rst = 1; run_code = 0; clk_half = 16'd2; settle_pulses = 16'd3;
        pd_word = 8'hA5; cfg_load = 0; adc_drdy = 0; adc_dout = 0; word_ready = 0;
        expect_idle();
        e_data = '0;
        repeat (3) cyc("R1 reset");
        rst = 0;
        repeat (3) cyc("R1 idle");

        // Run 1: N=2, three settle pulses, power-down byte loaded
        cfg_load = 1; run_code = 2'd1;
        startup(2, 3, 8'hA5);
        pd_word = 8'h3C; cfg_load = 1; clk_half = 16'd7;
        expect_wait();
        repeat (5) cyc("R3 R9 no data-ready edge, pd unchanged");

        smp = '{24'h123456, 24'hABCDEF, 24'h000000, 24'hFFFFFF,
                24'h800001, 24'h7FFFFE, 24'h5A5A5A, 24'h0F0F0F};
        stl = '{0, 0, 0, 0, 0, 0, 0, 0};
        frame(2, 1, -1);
        repeat (3) cyc("R3 idle wait between frames");

        smp = '{24'hC30FA5, 24'h000001, 24'h800000, 24'h3C3C3C,
                24'hDEAD12, 24'h654321, 24'hAAAAAA, 24'h555555};
        stl = '{0, 1, 2, 3, 0, 5, 1, 0};
        frame(2, 3, 4);
        expect_idle();
        cyc("R10 stopped at frame boundary");
        adc_drdy = 1;
        cyc("R10 data-ready ignored when stopped");
        adc_drdy = 0;
        repeat (6) cyc("R10 no frame after stop");

        // Run 2: clk_half 0 acts as 1, no settle pulses, no power-down load
        clk_half = 16'd0; settle_pulses = 16'd0; pd_word = 8'hFF; cfg_load = 0;
        run_code = 2'd1;
        startup(1, 0, 8'h00);
        smp = '{24'h00FF00, 24'hF0F0F0, 24'h123ABC, 24'hFFFFFE,
                24'h000000, 24'h7F7F7F, 24'h010203, 24'hE5E5E5};
        stl = '{1, 0, 0, 2, 0, 0, 0, 1};
        frame(1, 2, -1);
        run_code = 2'd0;
        expect_idle();
        cyc("R10 R8 stop after single-cycle frame");
        repeat (3) cyc("R1 idle after stop");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule